// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system use an external asynchronous static RAM of 256K words by 16 bits. On the system side it accepts one command at a time. A command carries an address, write data, a two-bit lane mask and a read/write flag. A ready flag gates acceptance. Read data comes back with a one-cycle valid strobe. On the memory side it drives registered, active-low chip, output, write and per-byte lane enables. It also drives an address bus and a data bus split into an outgoing value, an incoming value and a drive-enable.

Every timing limit of the memory is a nanosecond parameter. Each is turned into a cycle count by rounding up against the clock period. After reset the controller waits out the memory's power-up time before it accepts any command. A write is always ended by the write-enable rising edge while chip enable is still low. The data bus is driven only during the write-enable low window, so it is released well before output enable is asserted for a later read.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, `ready` stays low for ceil(1000 ns / clock period) clock edges (250 at 4 ns), and all memory controls stay inactive (high) during that time.
- R2: While `ready` is high, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and both bits of `mem_be_n` are high, and `mem_dq_oe` is low.
- R3: A command is taken only on an edge where `ready` is high. A `cmd_valid` presented while `ready` is low is ignored: it writes nothing, and a later read of that address returns the old content.
- R4: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for RD cycles (ceil(max(address access, read cycle) / period), 5 at 4 ns). `rd_valid` is high for exactly the one cycle after that, and `ready` returns high in that same cycle.
- R5: `cmd_mask` bit 0 enables the lane on data bits 7..0, and bit 1 the lane on bits 15..8. On a read, `mem_be_n` is the inverse of the mask. In `rd_data`, enabled lanes carry the memory word and disabled lanes are zero.
- R6: A write holds `mem_ce_n` and `mem_we_n` low, drives `mem_dq_o` with the write data and `mem_be_n` with the inverted mask for WR cycles. WR is the largest of ceil(13 ns), ceil(9 ns) and ceil(20 ns) minus one, in clock periods: 4 at 4 ns. Address, data and lanes stay stable across that window, and only enabled lanes change in memory.
- R7: A write ends with `mem_we_n` rising while `mem_ce_n` is still low. `mem_ce_n` rises one cycle later, and `ready` returns WR+1 cycles after acceptance.
- R8: `mem_dq_oe` is high only while `mem_we_n` is low, and `mem_oe_n` is never low while `mem_dq_oe` is high.
- R9: A new command may be accepted on the edge that closes the cycle in which `rd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 18 | Word address |
| cmd_wdata | input | 16 | Write data |
| cmd_mask | input | 2 | Lane enables, bit 0 = low byte |
| ready | output | 1 | Controller can take a command |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_i | input | 16 | Data returned by memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The read-data return and the acceptance of the next command can fall into the same cycle. `rd_valid` and a restored `ready` appear together, and a command waiting at the port is taken on the closing edge. The bench provokes this by holding `cmd_valid` high through a long random stream of mixed reads and writes. A behavioural reference predicts `ready`, `rd_valid` and `rd_data` on every clock. A memory model in the bench returns poison on disabled lanes and before the access time has elapsed. The bench also counts the overlap events, and the run must see at least one.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 4,
  parameter int T_PWR_NS  = 1000,
  parameter int T_AA_NS   = 20,
  parameter int T_RC_NS   = 20,
  parameter int T_PWE_NS  = 13,
  parameter int T_SD_NS   = 9,
  parameter int T_WC_NS   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [DATA_W/8-1:0] cmd_mask,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);
  localparam int LANES   = DATA_W / 8;
  localparam int PWR_CYC = (T_PWR_NS + CLK_NS - 1) / CLK_NS;
  localparam int AA_CYC  = (T_AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int RC_CYC  = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int PWE_CYC = (T_PWE_NS + CLK_NS - 1) / CLK_NS;
  localparam int SD_CYC  = (T_SD_NS + CLK_NS - 1) / CLK_NS;
  localparam int WC_CYC  = (T_WC_NS + CLK_NS - 1) / CLK_NS - 1;
  localparam int RD_T    = AA_CYC > RC_CYC ? AA_CYC : RC_CYC;
  localparam int RD_CYC  = RD_T > 1 ? RD_T : 1;
  localparam int WR_T0   = PWE_CYC > SD_CYC ? PWE_CYC : SD_CYC;
  localparam int WR_T1   = WR_T0 > WC_CYC ? WR_T0 : WC_CYC;
  localparam int WR_CYC  = WR_T1 > 1 ? WR_T1 : 1;
  localparam int CNT_M0  = PWR_CYC > RD_CYC ? PWR_CYC : RD_CYC;
  localparam int CNT_MAX = CNT_M0 > WR_CYC ? CNT_M0 : WR_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_BOOT, S_IDLE, S_RD, S_WR, S_REC} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  lane_bits;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_bits[8*i +: 8] = {8{~mem_be_n[i]}};
  end

  assign ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_BOOT;
      cnt       <= CNT_W'(PWR_CYC - 1);
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_be_n  <= '1;
      mem_dq_oe <= 1'b0;
      mem_dq_o  <= '0;
      mem_addr  <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_BOOT: if (cnt == '0) state <= S_IDLE; else cnt <= cnt - 1'b1;
        S_IDLE: if (cmd_valid) begin
          mem_addr <= cmd_addr;
          mem_be_n <= ~cmd_mask;
          mem_ce_n <= 1'b0;
          if (cmd_write) begin
            mem_we_n  <= 1'b0;
            mem_dq_oe <= 1'b1;
            mem_dq_o  <= cmd_wdata;
            cnt       <= CNT_W'(WR_CYC - 1);
            state     <= S_WR;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CNT_W'(RD_CYC - 1);
            state    <= S_RD;
          end
        end
        S_RD: if (cnt == '0) begin
          rd_data  <= mem_dq_i & lane_bits;
          rd_valid <= 1'b1;
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          mem_be_n <= '1;
          state    <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_WR: if (cnt == '0) begin
          mem_we_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          state     <= S_REC;
        end else cnt <= cnt - 1'b1;
        S_REC: begin
          mem_ce_n <= 1'b1;
          mem_be_n <= '1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_boot_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BOOT) |-> (mem_ce_n && mem_we_n && mem_oe_n));

  assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && mem_oe_n && mem_we_n && (&mem_be_n) && !mem_dq_oe));

  assert_valid_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ready);

  assert_we_in_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  assert_we_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);

  assert_oe_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  assert_drive_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);
endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
  localparam int TCK = 4;
  localparam int PWR = (1000 + TCK - 1) / TCK;
  localparam int RDC = (20 + TCK - 1) / TCK;
  localparam int WPE = (13 + TCK - 1) / TCK;
  localparam int WSD = (9 + TCK - 1) / TCK;
  localparam int WCY = (20 + TCK - 1) / TCK - 1;
  localparam int WRA = WPE > WSD ? WPE : WSD;
  localparam int WRC = WRA > WCY ? WRA : WCY;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_write;
  logic [17:0] cmd_addr;
  logic [15:0] cmd_wdata;
  logic [1:0]  cmd_mask;
  logic ready, rd_valid;
  logic [15:0] rd_data;
  logic [17:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_o, mem_dq_i;

  int checks = 0, errors = 0, b2b = 0;
  bit done = 0;

  always #(TCK/2) clk = ~clk;

  sram_async_ctrl #(.CLK_NS(TCK)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_mask(cmd_mask),
    .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
    .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe));

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] seed_word(logic [17:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'hC3};
  endfunction

  // memory model driven by the pins
  logic [15:0] sram [int];
  int rd_age = 0;
  logic [17:0] rd_addr_q = '0;
  int we_cycles = 0;
  logic [17:0] w_addr;
  logic [15:0] w_data;
  logic [1:0]  w_be;

  function automatic logic [15:0] sram_get(logic [17:0] a);
    return sram.exists(int'(a)) ? sram[int'(a)] : seed_word(a);
  endfunction

  always_comb begin
    logic [15:0] w;
    mem_dq_i = 16'hBEEF;
    if (!mem_ce_n && !mem_oe_n && mem_we_n && rd_age >= RDC - 1 && mem_addr == rd_addr_q) begin
      w = sram_get(mem_addr);
      mem_dq_i[7:0]  = mem_be_n[0] ? 8'hA5 : w[7:0];
      mem_dq_i[15:8] = mem_be_n[1] ? 8'hA5 : w[15:8];
    end
  end

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      if (rd_age == 0 || mem_addr != rd_addr_q) rd_age <= 1;
      else rd_age <= rd_age + 1;
    end else rd_age <= 0;
    rd_addr_q <= mem_addr;
  end

  always @(posedge clk) if (rst_n) begin
    if (!mem_we_n) begin
      chk(mem_dq_oe && !mem_ce_n, "R6 drive", {mem_dq_oe, mem_ce_n}, 2'b10);
      if (we_cycles > 0)
        chk(mem_dq_o == w_data && mem_addr == w_addr && mem_be_n == w_be, "R6 stable", mem_dq_o, w_data);
      w_addr = mem_addr; w_data = mem_dq_o; w_be = mem_be_n;
      we_cycles++;
    end else if (we_cycles > 0) begin
      chk(we_cycles >= WRC, "R6 width", we_cycles, WRC);
      chk(!mem_ce_n, "R7 ce at we rise", mem_ce_n, 0);
      begin
        logic [15:0] cur;
        cur = sram_get(w_addr);
        if (!w_be[0]) cur[7:0]  = w_data[7:0];
        if (!w_be[1]) cur[15:8] = w_data[15:8];
        sram[int'(w_addr)] = cur;
      end
      we_cycles = 0;
    end
    if (!mem_oe_n) chk(!mem_dq_oe, "R8 oe vs drive", mem_dq_oe, 0);
    if (mem_dq_oe) chk(!mem_we_n, "R8 drive vs we", mem_we_n, 0);
  end

  // behavioural reference of the port timing
  logic [15:0] ref_mem [int];
  int  m_busy;
  bit  m_rv, m_pend, m_boot;
  logic [15:0] m_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = PWR; m_rv = 0; m_pend = 0; m_boot = 1;
    end else begin
      bit old_rv;
      old_rv = m_rv;
      m_rv = 0;
      if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) begin
          m_boot = 0;
          if (m_pend) begin m_rv = 1; m_pend = 0; end
        end
      end else if (cmd_valid) begin
        logic [15:0] cur;
        if (old_rv) b2b++;
        cur = ref_mem.exists(int'(cmd_addr)) ? ref_mem[int'(cmd_addr)] : seed_word(cmd_addr);
        if (cmd_write) begin
          if (cmd_mask[0]) cur[7:0]  = cmd_wdata[7:0];
          if (cmd_mask[1]) cur[15:8] = cmd_wdata[15:8];
          ref_mem[int'(cmd_addr)] = cur;
          m_busy = WRC + 1;
        end else begin
          m_rd = {cmd_mask[1] ? cur[15:8] : 8'h00, cmd_mask[0] ? cur[7:0] : 8'h00};
          m_pend = 1;
          m_busy = RDC;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(ready === (m_busy == 0), m_boot ? "R1 ready" : "R3/R7 ready", ready, m_busy == 0);
    chk(rd_valid === m_rv, "R4 rd_valid", rd_valid, m_rv);
    if (m_rv) chk(rd_data === m_rd, "R5 rd_data", rd_data, m_rd);
    if (m_boot || m_busy == 0)
      chk(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe,
          m_boot ? "R1 quiet" : "R2 idle", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe}, 6'b111110);
  end

  task automatic issue(bit wr, logic [17:0] a, logic [15:0] d, logic [1:0] m);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_mask = m;
    @(negedge clk);
    cmd_valid = 0;
    while (!ready) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_write = 0; cmd_addr = '0; cmd_wdata = '0; cmd_mask = '0;
    repeat (5) @(negedge clk);
    chk(!ready && !rd_valid, "R1 reset", {ready, rd_valid}, 0);
    rst_n = 1;
    // R3: command during the power-up wait must be dropped
    cmd_valid = 1; cmd_write = 1; cmd_addr = 18'd5; cmd_wdata = 16'h1234; cmd_mask = 2'b11;
    repeat (20) @(negedge clk);
    cmd_valid = 0;
    while (!ready) @(negedge clk);
    issue(0, 18'd5, 16'h0, 2'b11);
    issue(1, 18'd7, 16'hA1B2, 2'b11);
    issue(0, 18'd7, 16'h0, 2'b11);
    issue(1, 18'd7, 16'h3C4D, 2'b01);
    issue(0, 18'd7, 16'h0, 2'b11);
    issue(1, 18'd7, 16'h9900, 2'b10);
    issue(0, 18'd7, 16'h0, 2'b01);
    issue(0, 18'd7, 16'h0, 2'b10);
    issue(0, 18'd7, 16'h0, 2'b00);
    // R9: command held waiting as reads complete
    for (int i = 0; i < 3000; i++) begin
      cmd_valid = ($urandom % 4) != 0;
      cmd_write = $urandom % 2;
      cmd_addr  = 18'($urandom % 16);
      cmd_wdata = 16'($urandom);
      cmd_mask  = 2'($urandom);
      @(negedge clk);
    end
    cmd_valid = 0;
    repeat (20) @(negedge clk);
    chk(b2b > 0, "R9 accept with rd_valid", b2b, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(TCK * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule